// File: doc/BRIEF.md
# Nanosecond Time-of-Day Counter with Staged Access

The block keeps the running time of day as a 48-bit seconds count and a 30-bit nanoseconds count. On every clock the nanoseconds advance by a fixed nominal step. When they pass the end of the second they wrap, and the seconds count up by one. A rate adjuster elsewhere on the chip can request a one-nanosecond correction on any cycle. The direction input chooses whether that nanosecond is added or taken away.

Software never touches the live time directly. It goes through three shadow registers (seconds high, seconds low, nanoseconds) and an action field. Writing the action field starts exactly one operation. Save copies the live time into the shadows in one step. Load replaces the live time with the shadow contents. Delta adds the shadow nanoseconds, read as a signed 30-bit value, to the live time, borrowing from or carrying into the seconds as needed.

A save makes up for its own capture latency by subtracting a fixed number of nanoseconds (SAVE_LAT_NS, at most 16). Just after a second boundary this can give a negative result. The saved nanoseconds field then holds a 30-bit two's-complement value from -16 to -1, and the saved seconds are not reduced. A reader converts such a value into the previous second plus (NS_PER_SEC - 16 + low four bits).

A small controller runs the operations. Its states are IDLE, SAVE, LOAD and DELTA. A write to the action field with code save, load or delta moves the controller from any state to SAVE, LOAD or DELTA for exactly one cycle. On the clock edge that ends that cycle the operation takes effect. The controller then returns to IDLE, unless another action write in that same cycle sends it straight to the next action state. A write of the idle code, or any cycle without an action write, leads to IDLE.

Top module: `tod_clock`

## Requirements
- R1: While rst_n is low, the live seconds, the live nanoseconds and all three shadow registers read zero.
- R2: On a cycle with no action and no correction, the live nanoseconds advance by INC_NS on every rising clock edge and always stay below NS_PER_SEC.
- R3: When the nanoseconds would reach or pass NS_PER_SEC, they wrap by subtracting NS_PER_SEC and the seconds go up by one. The seconds wrap from all ones to zero.
- R4: A correction pulse held high for one cycle changes that cycle's advance to INC_NS+1 when adj_slow is 0 and to INC_NS-1 when adj_slow is 1. Any resulting wrap or borrow follows R3.
- R5: Register addresses are: 0 = action, 1 = seconds high (data bits 15:0), 2 = seconds low (bits 31:0), 3 = nanoseconds (bits 29:0). Write bits above a field are dropped and read back as zero. The action address reads as zero.
- R6: An action write with code 1 (save) at clock edge E0 loads the shadows at edge E0+1. The shadow seconds get the live seconds seen between E0 and E0+1. The shadow nanoseconds get those live nanoseconds minus SAVE_LAT_NS.
- R7: When the live nanoseconds captured by a save are below SAVE_LAT_NS, the shadow nanoseconds hold the 30-bit two's-complement negative value and the shadow seconds are unchanged. The previous second plus (NS_PER_SEC - 16 + the low four bits) then gives back the compensated time.
- R8: An action write with code 2 (load) at edge E0 makes the live time equal the shadow seconds and nanoseconds after edge E0+1. Counting then goes on from there.
- R9: An action write with code 3 (delta) at edge E0 makes the live time after edge E0+1 equal the time seen between E0 and E0+1, plus INC_NS, plus the signed 30-bit shadow nanoseconds. The offset magnitude is below NS_PER_SEC/2.
- R10: A delta that takes the nanoseconds below zero borrows one second. A delta that takes them to NS_PER_SEC or above carries one second.
- R11: An action write with code 0 (idle) changes neither the shadows nor the normal advance of the live time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_waddr | input | 2 | Register write address |
| reg_wdata | input | 32 | Register write data |
| reg_raddr | input | 2 | Register read address |
| reg_rdata | output | 32 | Register read data (combinational) |
| adj_pulse | input | 1 | One-nanosecond correction request for this cycle |
| adj_slow | input | 1 | Correction direction: 0 adds, 1 removes |
| tod_sec | output | 48 | Live seconds |
| tod_ns | output | 30 | Live nanoseconds |

## Verification
The properties take for granted that every nanoseconds value loaded into the live time is below NS_PER_SEC. They also take for granted that every delta offset has a magnitude below half a second and that SAVE_LAT_NS does not exceed 16. If any of these is broken, the range and advance checks could fire against a correct design. The bench runs a small configuration with a 100 ns second. It loads only nanosecond values it draws from 0 to 99 and offsets from -49 to 49, and it sweeps load phases across the whole second so that saves land just below and just above the compensation threshold.

// File: rtl/tod_pkg.sv
package tod_pkg;

    // Action codes written to the action register (bits 1:0)
    typedef enum logic [1:0] {
        ACT_IDLE  = 2'd0,
        ACT_SAVE  = 2'd1,
        ACT_LOAD  = 2'd2,
        ACT_DELTA = 2'd3
    } tod_act_e;

    // Controller states
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SAVE  = 2'd1,
        ST_LOAD  = 2'd2,
        ST_DELTA = 2'd3
    } tod_state_e;

    // One-cycle operation strobes from the controller
    typedef struct packed {
        logic save;
        logic load;
        logic delta;
    } tod_op_t;

    localparam logic [1:0] ADDR_ACTION = 2'd0;
    localparam logic [1:0] ADDR_SEC_HI = 2'd1;
    localparam logic [1:0] ADDR_SEC_LO = 2'd2;
    localparam logic [1:0] ADDR_NSEC   = 2'd3;

endpackage

// File: rtl/tod_ctrl.sv
module tod_ctrl
    import tod_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       act_wr,
    input  logic [1:0] act_code,
    output tod_state_e state_o,
    output tod_op_t    op_o
);

    tod_state_e state_q;
    tod_state_e state_n;

    // Next-state logic: every action state lasts one cycle
    always_comb begin
        state_n = ST_IDLE;
        if (act_wr) begin
            unique case (act_code)
                ACT_SAVE:  state_n = ST_SAVE;
                ACT_LOAD:  state_n = ST_LOAD;
                ACT_DELTA: state_n = ST_DELTA;
                default:   state_n = ST_IDLE;
            endcase
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_n;
    end

    // Outputs decoded from the state
    always_comb begin
        op_o = '0;
        unique case (state_q)
            ST_IDLE:  op_o = '0;
            ST_SAVE:  op_o.save  = 1'b1;
            ST_LOAD:  op_o.load  = 1'b1;
            ST_DELTA: op_o.delta = 1'b1;
            default:  op_o = '0;
        endcase
    end

    assign state_o = state_q;

endmodule

// File: rtl/tod_regs.sv
module tod_regs
    import tod_pkg::*;
#(
    parameter int SEC_W  = 48,
    parameter int NS_W   = 30,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [1:0]        wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [1:0]        rd_addr,
    output logic [DATA_W-1:0] rd_data,
    input  logic              snap_en,
    input  logic [SEC_W-1:0]  snap_sec,
    input  logic [NS_W-1:0]   snap_ns,
    output logic [SEC_W-1:0]  sh_sec,
    output logic [NS_W-1:0]   sh_ns,
    output logic              act_wr,
    output logic [1:0]        act_code
);

    localparam int LO_W = DATA_W;
    localparam int HI_W = SEC_W - DATA_W;

    logic [HI_W-1:0] hi_q;
    logic [LO_W-1:0] lo_q;
    logic [NS_W-1:0] ns_q;

    // A snapshot takes priority over a register write in the same cycle
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hi_q <= '0;
            lo_q <= '0;
            ns_q <= '0;
        end else if (snap_en) begin
            hi_q <= snap_sec[SEC_W-1:LO_W];
            lo_q <= snap_sec[LO_W-1:0];
            ns_q <= snap_ns;
        end else if (wr_en) begin
            unique case (wr_addr)
                ADDR_SEC_HI: hi_q <= wr_data[HI_W-1:0];
                ADDR_SEC_LO: lo_q <= wr_data[LO_W-1:0];
                ADDR_NSEC:   ns_q <= wr_data[NS_W-1:0];
                default:     ;
            endcase
        end
    end

    always_comb begin
        rd_data = '0;
        unique case (rd_addr)
            ADDR_SEC_HI: rd_data[HI_W-1:0] = hi_q;
            ADDR_SEC_LO: rd_data[LO_W-1:0] = lo_q;
            ADDR_NSEC:   rd_data[NS_W-1:0] = ns_q;
            default:     rd_data = '0;
        endcase
    end

    assign sh_sec   = {hi_q, lo_q};
    assign sh_ns    = ns_q;
    assign act_wr   = wr_en && (wr_addr == ADDR_ACTION);
    assign act_code = wr_data[1:0];

endmodule

// File: rtl/tod_counter.sv
module tod_counter
    import tod_pkg::*;
#(
    parameter int SEC_W       = 48,
    parameter int NS_W        = 30,
    parameter int NS_PER_SEC  = 1000000000,
    parameter int INC_NS      = 4,
    parameter int SAVE_LAT_NS = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  tod_op_t          op,
    input  logic             corr_pulse,
    input  logic             corr_dir,
    input  logic [SEC_W-1:0] sh_sec,
    input  logic [NS_W-1:0]  sh_ns,
    output logic [SEC_W-1:0] sec_o,
    output logic [NS_W-1:0]  ns_o,
    output logic [NS_W-1:0]  snap_ns
);

    localparam int SW = NS_W + 3;
    localparam logic signed [SW-1:0] NPS_S   = SW'(NS_PER_SEC);
    localparam logic signed [SW-1:0] INC_S   = SW'(INC_NS);
    localparam logic signed [SW-1:0] ONE_POS = SW'(1);
    localparam logic signed [SW-1:0] ONE_NEG = -SW'(1);
    localparam logic [SEC_W-1:0]     SEC_ONE = SEC_W'(1);

    logic [SEC_W-1:0]        sec_q, sec_n;
    logic [NS_W-1:0]         ns_q, ns_n;
    logic signed [SW-1:0]    corr_s, delta_s, step, sum, fix;

    // Sign-extended shadow nanoseconds used as the delta offset
    assign delta_s = $signed({{(SW-NS_W){sh_ns[NS_W-1]}}, sh_ns});

    always_comb begin
        corr_s = '0;
        if (corr_pulse) corr_s = corr_dir ? ONE_NEG : ONE_POS;
        step = INC_S + corr_s + (op.delta ? delta_s : '0);
        sum  = $signed({{(SW-NS_W){1'b0}}, ns_q}) + step;
        fix  = sum;
        sec_n = sec_q;
        if (sum < 0) begin
            fix   = sum + NPS_S;
            sec_n = sec_q - SEC_ONE;
        end else if (sum >= NPS_S) begin
            fix   = sum - NPS_S;
            sec_n = sec_q + SEC_ONE;
        end
        ns_n = fix[NS_W-1:0];
        if (op.load) begin
            sec_n = sh_sec;
            ns_n  = sh_ns;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sec_q <= '0;
            ns_q  <= '0;
        end else begin
            sec_q <= sec_n;
            ns_q  <= ns_n;
        end
    end

    // Latency-compensated snapshot; wraps to a negative 30-bit code
    generate
        if (SAVE_LAT_NS == 0) begin : g_no_comp
            assign snap_ns = ns_q;
        end else begin : g_comp
            localparam logic [NS_W-1:0] LAT_V = NS_W'(SAVE_LAT_NS);
            assign snap_ns = ns_q - LAT_V;
        end
    endgenerate

    assign sec_o = sec_q;
    assign ns_o  = ns_q;

endmodule

// File: rtl/tod_clock.sv
module tod_clock
    import tod_pkg::*;
#(
    parameter int SEC_W       = 48,
    parameter int NS_W        = 30,
    parameter int NS_PER_SEC  = 1000000000,
    parameter int INC_NS      = 4,
    parameter int SAVE_LAT_NS = 8
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_wr,
    input  logic [1:0]  reg_waddr,
    input  logic [31:0] reg_wdata,
    input  logic [1:0]  reg_raddr,
    output logic [31:0] reg_rdata,
    input  logic        adj_pulse,
    input  logic        adj_slow,
    output logic [47:0] tod_sec,
    output logic [29:0] tod_ns
);

    logic [SEC_W-1:0] sh_sec;
    logic [NS_W-1:0]  sh_ns;
    logic [NS_W-1:0]  snap_ns;
    logic             act_wr;
    logic [1:0]       act_code;
    tod_state_e       op_state;
    tod_op_t          op;

    tod_regs #(.SEC_W(SEC_W), .NS_W(NS_W), .DATA_W(32)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (reg_wr),
        .wr_addr  (reg_waddr),
        .wr_data  (reg_wdata),
        .rd_addr  (reg_raddr),
        .rd_data  (reg_rdata),
        .snap_en  (op.save),
        .snap_sec (tod_sec),
        .snap_ns  (snap_ns),
        .sh_sec   (sh_sec),
        .sh_ns    (sh_ns),
        .act_wr   (act_wr),
        .act_code (act_code)
    );

    tod_ctrl u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .act_wr   (act_wr),
        .act_code (act_code),
        .state_o  (op_state),
        .op_o     (op)
    );

    tod_counter #(
        .SEC_W       (SEC_W),
        .NS_W        (NS_W),
        .NS_PER_SEC  (NS_PER_SEC),
        .INC_NS      (INC_NS),
        .SAVE_LAT_NS (SAVE_LAT_NS)
    ) u_cnt (
        .clk        (clk),
        .rst_n      (rst_n),
        .op         (op),
        .corr_pulse (adj_pulse),
        .corr_dir   (adj_slow),
        .sh_sec     (sh_sec),
        .sh_ns      (sh_ns),
        .sec_o      (tod_sec),
        .ns_o       (tod_ns),
        .snap_ns    (snap_ns)
    );

endmodule

// File: rtl/tod_clock_chk.sv
module tod_clock_chk
    import tod_pkg::*;
#(
    parameter int SEC_W       = 48,
    parameter int NS_W        = 30,
    parameter int NS_PER_SEC  = 1000000000,
    parameter int INC_NS      = 4,
    parameter int SAVE_LAT_NS = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic [SEC_W-1:0] tod_sec,
    input logic [NS_W-1:0]  tod_ns,
    input logic             adj_pulse,
    input logic             adj_slow,
    input tod_state_e       st,
    input logic [SEC_W-1:0] sh_sec,
    input logic [NS_W-1:0]  sh_ns
);

    localparam logic [31:0]      NPS32 = 32'(NS_PER_SEC);
    localparam logic [31:0]      INC32 = 32'(INC_NS);
    localparam logic [NS_W-1:0]  LATV  = NS_W'(SAVE_LAT_NS);
    localparam logic [SEC_W-1:0] S1    = SEC_W'(1);

    // R2: live nanoseconds always in range
    p_ns_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
        32'(tod_ns) < NPS32);

    // R2, R3: plain advance with wrap
    p_tick_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_IDLE && !adj_pulse) |=>
        ((32'(tod_ns) == 32'($past(tod_ns)) + INC32 && tod_sec == $past(tod_sec)) ||
         (32'(tod_ns) + NPS32 == 32'($past(tod_ns)) + INC32 && tod_sec == $past(tod_sec) + S1)));

    // R4: correction adds one nanosecond
    p_corr_fast_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_IDLE && adj_pulse && !adj_slow) |=>
        ((32'(tod_ns) == 32'($past(tod_ns)) + INC32 + 32'd1 && tod_sec == $past(tod_sec)) ||
         (32'(tod_ns) + NPS32 == 32'($past(tod_ns)) + INC32 + 32'd1 && tod_sec == $past(tod_sec) + S1)));

    // R4: correction removes one nanosecond
    p_corr_slow_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_IDLE && adj_pulse && adj_slow) |=>
        ((32'(tod_ns) + 32'd1 == 32'($past(tod_ns)) + INC32 && tod_sec == $past(tod_sec)) ||
         (32'(tod_ns) + NPS32 + 32'd1 == 32'($past(tod_ns)) + INC32 && tod_sec == $past(tod_sec) + S1)));

    // R6, R7: snapshot holds the compensated live time
    p_save_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_SAVE) |=>
        (sh_sec == $past(tod_sec) && sh_ns == $past(tod_ns) - LATV));

    // R8: load copies the shadows into the live time
    p_load_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_LOAD) |=>
        (tod_sec == $past(sh_sec) && tod_ns == $past(sh_ns)));

endmodule

bind tod_clock tod_clock_chk #(
    .SEC_W       (SEC_W),
    .NS_W        (NS_W),
    .NS_PER_SEC  (NS_PER_SEC),
    .INC_NS      (INC_NS),
    .SAVE_LAT_NS (SAVE_LAT_NS)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .tod_sec   (tod_sec),
    .tod_ns    (tod_ns),
    .adj_pulse (adj_pulse),
    .adj_slow  (adj_slow),
    .st        (op_state),
    .sh_sec    (sh_sec),
    .sh_ns     (sh_ns)
);

// File: tb/tod_clock_bench.sv
module tod_clock_bench;

    localparam int  NPS = 100;
    localparam int  INC = 3;
    localparam int  LAT = 5;
    localparam longint TWO30 = 64'd1 << 30;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [1:0]  reg_waddr = '0;
    logic [31:0] reg_wdata = '0;
    logic [1:0]  reg_raddr = '0;
    logic [31:0] reg_rdata;
    logic        adj_pulse = 1'b0;
    logic        adj_slow = 1'b0;
    logic [47:0] tod_sec;
    logic [29:0] tod_ns;

    int nchk = 0;
    int nerr = 0;

    always #2 clk = ~clk;

    tod_clock #(
        .SEC_W(48), .NS_W(30), .NS_PER_SEC(NPS), .INC_NS(INC), .SAVE_LAT_NS(LAT)
    ) u_tod_clock (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_waddr(reg_waddr),
        .reg_wdata(reg_wdata), .reg_raddr(reg_raddr), .reg_rdata(reg_rdata),
        .adj_pulse(adj_pulse), .adj_slow(adj_slow), .tod_sec(tod_sec), .tod_ns(tod_ns)
    );

    task automatic chk(input string req, input longint act, input longint exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Normalise a time after adding an offset in nanoseconds
    task automatic nrm(input logic [47:0] s, input longint n,
                       output logic [47:0] so, output longint no);
        so = s; no = n;
        if (no < 0) begin no += NPS; so = s - 48'd1; end
        else if (no >= NPS) begin no -= NPS; so = s + 48'd1; end
    endtask

    task automatic reg_write(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_waddr = a; reg_wdata = d;
        @(posedge clk);
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    // Issue an action; returns the live time seen in the action cycle,
    // and comes back at the negedge after the action took effect
    task automatic do_action(input logic [1:0] code,
                             output logic [47:0] ts, output longint tn);
        reg_write(2'd0, {30'd0, code});
        ts = tod_sec; tn = longint'(tod_ns);
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] d);
        reg_raddr = a;
        #0.5;
        d = reg_rdata;
    endtask

    task automatic load_time(input logic [47:0] s, input longint n);
        logic [47:0] ts; longint tn;
        reg_write(2'd1, {16'd0, s[47:32]});
        reg_write(2'd2, s[31:0]);
        reg_write(2'd3, 32'(n));
        do_action(2'd2, ts, tn);
    endtask

    initial begin
        #(4 * 200000);
        nerr++; nchk++;
        $display("FAIL watchdog actual=timeout expected=finished");
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

    initial begin
        logic [47:0] ps, es, ts, ss;
        longint pn, en, tn;
        logic [31:0] d, hi, lo, nsr;

        // R1: reset state
        #7;
        rd(2'd1, hi); rd(2'd2, lo); rd(2'd3, nsr);
        chk("R1 sec", longint'(tod_sec), 0);
        chk("R1 ns", longint'(tod_ns), 0);
        chk("R1 shadow hi", longint'(hi), 0);
        chk("R1 shadow lo", longint'(lo), 0);
        chk("R1 shadow ns", longint'(nsr), 0);
        @(negedge clk);
        rst_n = 1'b1;

        // R2, R3: free running advance over several seconds
        @(negedge clk);
        for (int i = 0; i < 300; i++) begin
            ps = tod_sec; pn = longint'(tod_ns);
            @(negedge clk);
            nrm(ps, pn + INC, es, en);
            chk((es != ps) ? "R3 wrap" : "R2 advance", longint'(tod_ns), en);
            chk("R3 sec", longint'(tod_sec), longint'(es));
        end

        // R5: field widths and read-back
        reg_write(2'd1, 32'hABCD_1234);
        reg_write(2'd2, 32'hDEAD_BEEF);
        reg_write(2'd3, 32'hFFFF_FFFF);
        rd(2'd1, hi); rd(2'd2, lo); rd(2'd3, nsr); rd(2'd0, d);
        chk("R5 sec hi", longint'(hi), 64'h1234);
        chk("R5 sec lo", longint'(lo), 64'hDEAD_BEEF);
        chk("R5 ns", longint'(nsr), 64'h3FFF_FFFF);
        chk("R5 action reads zero", longint'(d), 0);

        // R8: load sweep across the second
        for (int x = 0; x < NPS; x += 7) begin
            load_time(48'(x * 1000 + 5), x);
            chk("R8 load ns", longint'(tod_ns), x);
            chk("R8 load sec", longint'(tod_sec), x * 1000 + 5);
            ps = tod_sec; pn = longint'(tod_ns);
            @(negedge clk);
            nrm(ps, pn + INC, es, en);
            chk("R8 count after load", longint'(tod_ns), en);
        end

        // R3: seconds wrap at all ones
        load_time(48'hFFFF_FFFF_FFFF, NPS - 1);
        @(negedge clk);
        chk("R3 sec wrap", longint'(tod_sec), 0);
        chk("R3 ns wrap", longint'(tod_ns), NPS - 1 + INC - NPS);

        // R6, R7: save sweep over every load phase
        for (int x = 0; x < NPS; x++) begin
            load_time(48'(77 + x), x);
            do_action(2'd1, ts, tn);
            rd(2'd1, hi); rd(2'd2, lo); rd(2'd3, nsr);
            ss = {hi[15:0], lo};
            chk("R6 save sec", longint'(ss), longint'(ts));
            if (tn >= LAT) begin
                chk("R6 save ns", longint'(nsr), tn - LAT);
            end else begin
                chk("R7 negative ns code", longint'(nsr), TWO30 + tn - LAT);
                chk("R7 rebuilt sec", longint'(ss - 48'd1), longint'(ts - 48'd1));
                chk("R7 rebuilt ns", longint'(NPS - 16 + nsr[3:0]), tn - LAT + NPS);
            end
        end

        // R9, R10: delta sweep over phases and offsets
        for (int x = 0; x < NPS; x += 11) begin
            for (int dd = -(NPS / 2 - 1); dd <= NPS / 2 - 1; dd += 4) begin
                load_time(48'(5000 + x), x);
                reg_write(2'd3, 32'(dd) & 32'h3FFF_FFFF);
                do_action(2'd3, ts, tn);
                nrm(ts, tn + INC + dd, es, en);
                chk((es != ts) ? "R10 delta carry" : "R9 delta ns", longint'(tod_ns), en);
                chk((es != ts) ? "R10 delta sec" : "R9 delta sec", longint'(tod_sec), longint'(es));
            end
        end

        // R4: corrections near and away from the boundary
        for (int k = 0; k < 16; k++) begin
            load_time(48'd9, NPS - 8 + k / 2);
            ps = tod_sec; pn = longint'(tod_ns);
            adj_pulse = 1'b1; adj_slow = k[0];
            @(posedge clk);
            @(negedge clk);
            adj_pulse = 1'b0;
            nrm(ps, pn + INC + (k[0] ? -1 : 1), es, en);
            chk("R4 corr ns", longint'(tod_ns), en);
            chk("R4 corr sec", longint'(tod_sec), longint'(es));
        end

        // R11: idle action changes nothing
        reg_write(2'd3, 32'd42);
        rd(2'd1, hi); rd(2'd2, lo);
        do_action(2'd0, ts, tn);
        nrm(ts, tn + INC, es, en);
        chk("R11 idle ns", longint'(tod_ns), en);
        chk("R11 idle sec", longint'(tod_sec), longint'(es));
        rd(2'd3, nsr);
        chk("R11 shadow ns kept", longint'(nsr), 42);
        rd(2'd1, d);
        chk("R11 shadow hi kept", longint'(d), longint'(hi));
        rd(2'd2, d);
        chk("R11 shadow lo kept", longint'(d), longint'(lo));

        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

endmodule